// File: doc/BRIEF.md
# MMU Special Register Access Controller

This block is the software-facing register port of a memory management unit. A small single-cycle bus selects one of six registers by number: the process identifier, the zone protection word, the entry index, a data window, a tag window and a search trigger. The two windows give indirect access to a set of translation entries, each holding a tag word, a data word and a translation ID. The index register picks which entry the windows address.

Several accesses have side effects. Writing the tag window captures the current process identifier as the entry's translation ID. Reading the tag window loads the process identifier from that entry's translation ID. Writing the search register runs an associative lookup over all entries and leaves the result in the index register. Changing the process identifier or the zone word raises one-cycle invalidate pulses, which a downstream translation cache can use to drop stale entries. Two configuration inputs, a mode and an access level, decide which accesses are permitted. A refused access is flagged on an error output.

Top module: `mmu_sreg_ctrl`

## Requirements
- R1: When the mode input is below 2 or the access level is 0, every request is refused, whatever register it addresses.
- R2: A refused request raises the error output for exactly the next cycle, changes no register or entry, raises no invalidate pulse and, if it is a read, returns zero.
- R3: Register numbers are 0 process identifier, 1 zone word, 2 index, 3 data window, 4 tag window, 5 search. Reads of 0, 1, 3 and 4 need access level bit 0 set. Reads of 2 are always permitted once R1 is met. Reads of 5, 6 and 7 return zero without error.
- R4: Writes to 0, 1 and 5 need an access level of 2 or more. Writes to 2, 3 and 4 need only an access level above 0. Writes to 6 and 7 are ignored without error.
- R5: The windows address the entry given by the low log2(entries) bits of the index register. Read data appears on the output in the cycle after the request and holds until the next read.
- R6: A permitted tag window write stores the word and records the low 8 bits of the current process identifier as that entry's translation ID.
- R7: A permitted tag window read returns the tag word and loads the process identifier with that entry's translation ID.
- R8: A permitted search write looks up the written value with bits 9:0 cleared. An entry matches when the key and its tag agree on all bits above the entry's page span. The span is 1 KiB shifted left by twice the 3-bit size code in tag bits 9:7. The index register takes the lowest matching entry number, or 0x8000_0000 (bit 31 set, rest zero) on a miss.
- R9: The search skips entries whose valid bit (tag bit 6) is clear, entries with size code 0, and entries whose nonzero translation ID differs from the process identifier. A translation ID of zero matches any process identifier.
- R10: A permitted process identifier write whose low 8 bits differ from the stored value pulses, for one cycle, the invalidate line of every entry with a nonzero translation ID equal to the old value. A write of the same value pulses nothing.
- R11: A permitted zone word write of a different value pulses the global invalidate output for one cycle. A write of the same value does not.
- R12: After reset every register, entry, output and pulse is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | MMU mode; below 2 disables the register port |
| cfg_access | input | 2 | Access level for entries and control registers |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_we | input | 1 | 1 = write, 0 = read |
| req_reg | input | 3 | Register number |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| req_err | output | 1 | One-cycle refusal flag |
| inval_entries | output | N_ENTRIES | Per-entry invalidate pulses after an identifier change |
| inval_all | output | 1 | Global invalidate pulse after a zone word change |

## Verification
The assertions assume that the configuration inputs stay stable around each request. They also assume that a request lasts exactly one cycle, with no dependence between back-to-back requests beyond the registered state. The bench changes the mode and access level only between requests and drives each request for a single cycle, away from the clock edge. It sweeps every mode, access level, register number and direction, and runs a search grid across page edges and identifiers. A reference model built from the requirements predicts every output.

// File: rtl/mmu_sreg_pkg.sv
// Shared constants, register numbers and helpers for the MMU register port.
// Assumes 32-bit register words and 8-bit translation IDs.
package mmu_sreg_pkg;

    localparam int REG_W     = 3;
    localparam int DATA_W    = 32;
    localparam int TID_W     = 8;
    localparam int VALID_BIT = 6;
    localparam int SIZE_LSB  = 7;
    localparam int SIZE_W    = 3;
    localparam int EPN_LSB   = 10;
    localparam int MISS_BIT  = 31;

    localparam logic [DATA_W-1:0] EPN_MASK = ~((32'd1 << EPN_LSB) - 32'd1);
    localparam logic [DATA_W-1:0] MISS_WORD = 32'd1 << MISS_BIT;

    typedef enum logic [REG_W-1:0] {
        RID_PID    = 3'd0,
        RID_ZONE   = 3'd1,
        RID_INDEX  = 3'd2,
        RID_DWIN   = 3'd3,
        RID_TWIN   = 3'd4,
        RID_SEARCH = 3'd5
    } reg_id_e;

    // Mask keeping the address bits above a page of the given size code.
    function automatic logic [DATA_W-1:0] page_mask(input logic [SIZE_W-1:0] code);
        logic [DATA_W-1:0] span;
        span = 32'd1 << (EPN_LSB + 2 * int'(code));
        return ~(span - 32'd1);
    endfunction

endpackage

// File: rtl/mmu_access_policy.sv
// Decides whether a register request is permitted under the current mode
// and access level. Purely combinational; assumes one request per cycle.
module mmu_access_policy
    import mmu_sreg_pkg::*;
(
    input  logic             req_valid,
    input  logic             req_we,
    input  logic [REG_W-1:0] req_reg,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_access,
    output logic             accept,
    output logic             refuse
);

    logic blocked;
    logic read_needs_low;
    logic write_needs_high;
    logic denied;

    // Classify the register and combine with the configuration.
    always_comb begin
        blocked          = (cfg_mode < 2'd2) || (cfg_access == 2'd0);
        read_needs_low   = 1'b0;
        write_needs_high = 1'b0;
        case (req_reg)
            RID_PID, RID_ZONE:   begin read_needs_low = 1'b1; write_needs_high = 1'b1; end
            RID_DWIN, RID_TWIN:  read_needs_low = 1'b1;
            RID_SEARCH:          write_needs_high = 1'b1;
            default:             ;
        endcase
        denied = blocked
               || (!req_we && read_needs_low && !cfg_access[0])
               || ( req_we && write_needs_high && (cfg_access < 2'd2));
        accept = req_valid && !denied;
        refuse = req_valid &&  denied;
    end

endmodule

// File: rtl/mmu_entry_store.sv
// Holds the tag word, data word and translation ID of every entry.
// One write port (tag or data, with the ID captured on tag writes) and
// an asynchronous read port; all contents clear on reset.
module mmu_entry_store
    import mmu_sreg_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic                              wr_sel_tag,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [DATA_W-1:0]                 wr_value,
    input  logic [TID_W-1:0]                  wr_tid,
    input  logic [IDX_W-1:0]                  rd_idx,
    output logic [DATA_W-1:0]                 rd_tag,
    output logic [DATA_W-1:0]                 rd_dat,
    output logic [TID_W-1:0]                  rd_tid,
    output logic [N_ENTRIES-1:0][DATA_W-1:0]  tag_all,
    output logic [N_ENTRIES-1:0][TID_W-1:0]   tid_all
);

    logic [N_ENTRIES-1:0][DATA_W-1:0] dat_all;

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_entry
        logic hit_wr;
        assign hit_wr = wr_en && (wr_idx == IDX_W'(e));

        // Update one entry's tag, ID and data words.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_all[e] <= '0;
                tid_all[e] <= '0;
                dat_all[e] <= '0;
            end else if (hit_wr && wr_sel_tag) begin
                tag_all[e] <= wr_value;
                tid_all[e] <= wr_tid;
            end else if (hit_wr) begin
                dat_all[e] <= wr_value;
            end
        end
    end

    // Present the selected entry on the read port.
    always_comb begin
        rd_tag = tag_all[rd_idx];
        rd_dat = dat_all[rd_idx];
        rd_tid = tid_all[rd_idx];
    end

endmodule

// File: rtl/mmu_tag_search.sv
// Associative lookup of a key over all entries. An entry matches when it
// is valid, has a supported page size, agrees above its page span and its
// ID is zero or equals the current identifier. Lowest entry wins.
module mmu_tag_search
    import mmu_sreg_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = $clog2(N_ENTRIES)
) (
    input  logic [DATA_W-1:0]                 key,
    input  logic [TID_W-1:0]                  pid,
    input  logic [N_ENTRIES-1:0][DATA_W-1:0]  tag_all,
    input  logic [N_ENTRIES-1:0][TID_W-1:0]   tid_all,
    output logic                              hit,
    output logic [IDX_W-1:0]                  hit_idx
);

    logic [N_ENTRIES-1:0] match;

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
        logic [SIZE_W-1:0] code;
        logic [DATA_W-1:0] mask;
        logic              addr_eq;
        logic              id_ok;

        // Compare one entry against the key.
        always_comb begin
            code     = tag_all[e][SIZE_LSB +: SIZE_W];
            mask     = EPN_MASK & page_mask(code);
            addr_eq  = (key & mask) == (tag_all[e] & mask);
            id_ok    = (tid_all[e] == '0) || (tid_all[e] == pid);
            match[e] = tag_all[e][VALID_BIT] && (code != '0) && addr_eq && id_ok;
        end
    end

    // Pick the lowest matching entry.
    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/mmu_sreg_ctrl.sv
// Register port of the MMU: identifier, zone word, index, two entry
// windows and a search trigger, with permission checks and invalidate
// pulses. Assumes N_ENTRIES is a power of two between 2 and 256 and one
// request per cycle; all state uses a synchronous active-low reset.
module mmu_sreg_ctrl
    import mmu_sreg_pkg::*;
#(
    parameter int N_ENTRIES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_mode,
    input  logic [1:0]           cfg_access,
    input  logic                 req_valid,
    input  logic                 req_we,
    input  logic [2:0]           req_reg,
    input  logic [31:0]          req_wdata,
    output logic [31:0]          rd_data,
    output logic                 req_err,
    output logic [N_ENTRIES-1:0] inval_entries,
    output logic                 inval_all
);

    localparam int IDX_W = $clog2(N_ENTRIES);

    logic                             accept;
    logic                             refuse;
    logic                             is_wr;
    logic                             is_rd;
    logic [TID_W-1:0]                 pid_q;
    logic [DATA_W-1:0]                zone_q;
    logic [DATA_W-1:0]                index_q;
    logic [DATA_W-1:0]                rd_data_q;
    logic                             err_q;
    logic [N_ENTRIES-1:0]             inval_q;
    logic                             inval_all_q;
    logic [IDX_W-1:0]                 cur_idx;
    logic                             store_wr;
    logic [DATA_W-1:0]                sel_tag;
    logic [DATA_W-1:0]                sel_dat;
    logic [TID_W-1:0]                 sel_tid;
    logic [N_ENTRIES-1:0][DATA_W-1:0] tag_all;
    logic [N_ENTRIES-1:0][TID_W-1:0]  tid_all;
    logic                             hit;
    logic [IDX_W-1:0]                 hit_idx;
    logic [N_ENTRIES-1:0]             owned;
    logic                             pid_change;
    logic                             zone_change;
    logic [DATA_W-1:0]                rd_mux;

    mmu_access_policy u_policy (
        .req_valid  (req_valid),
        .req_we     (req_we),
        .req_reg    (req_reg),
        .cfg_mode   (cfg_mode),
        .cfg_access (cfg_access),
        .accept     (accept),
        .refuse     (refuse)
    );

    // Qualify the permitted request and select the addressed entry.
    always_comb begin
        is_wr    = accept &&  req_we;
        is_rd    = accept && !req_we;
        cur_idx  = index_q[IDX_W-1:0];
        store_wr = is_wr && ((req_reg == RID_DWIN) || (req_reg == RID_TWIN));
    end

    mmu_entry_store #(
        .N_ENTRIES (N_ENTRIES),
        .IDX_W     (IDX_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (store_wr),
        .wr_sel_tag (req_reg == RID_TWIN),
        .wr_idx     (cur_idx),
        .wr_value   (req_wdata),
        .wr_tid     (pid_q),
        .rd_idx     (cur_idx),
        .rd_tag     (sel_tag),
        .rd_dat     (sel_dat),
        .rd_tid     (sel_tid),
        .tag_all    (tag_all),
        .tid_all    (tid_all)
    );

    mmu_tag_search #(
        .N_ENTRIES (N_ENTRIES),
        .IDX_W     (IDX_W)
    ) u_search (
        .key     (req_wdata & EPN_MASK),
        .pid     (pid_q),
        .tag_all (tag_all),
        .tid_all (tid_all),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_owned
        assign owned[e] = (tid_all[e] != '0) && (tid_all[e] == pid_q);
    end

    // Detect value changes that require invalidation.
    always_comb begin
        pid_change  = is_wr && (req_reg == RID_PID)  && (req_wdata[TID_W-1:0] != pid_q);
        zone_change = is_wr && (req_reg == RID_ZONE) && (req_wdata != zone_q);
    end

    // Read multiplexer over the register set.
    always_comb begin
        case (req_reg)
            RID_PID:   rd_mux = {{(DATA_W-TID_W){1'b0}}, pid_q};
            RID_ZONE:  rd_mux = zone_q;
            RID_INDEX: rd_mux = index_q;
            RID_DWIN:  rd_mux = sel_dat;
            RID_TWIN:  rd_mux = sel_tag;
            default:   rd_mux = '0;
        endcase
    end

    // Identifier: written directly or reloaded by a tag window read.
    always_ff @(posedge clk) begin
        if (!rst_n)                                pid_q <= '0;
        else if (is_wr && (req_reg == RID_PID))    pid_q <= req_wdata[TID_W-1:0];
        else if (is_rd && (req_reg == RID_TWIN))   pid_q <= sel_tid;
    end

    // Zone protection word.
    always_ff @(posedge clk) begin
        if (!rst_n)                                zone_q <= '0;
        else if (is_wr && (req_reg == RID_ZONE))   zone_q <= req_wdata;
    end

    // Index register: direct writes and search results.
    always_ff @(posedge clk) begin
        if (!rst_n)
            index_q <= '0;
        else if (is_wr && (req_reg == RID_INDEX))
            index_q <= req_wdata;
        else if (is_wr && (req_reg == RID_SEARCH))
            index_q <= hit ? {{(DATA_W-IDX_W){1'b0}}, hit_idx} : MISS_WORD;
    end

    // Registered read data; a refused read returns zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                   rd_data_q <= '0;
        else if (refuse && !req_we)   rd_data_q <= '0;
        else if (is_rd)               rd_data_q <= rd_mux;
    end

    // One-cycle error and invalidate pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q       <= 1'b0;
            inval_q     <= '0;
            inval_all_q <= 1'b0;
        end else begin
            err_q       <= refuse;
            inval_q     <= pid_change ? owned : '0;
            inval_all_q <= zone_change;
        end
    end

    assign rd_data       = rd_data_q;
    assign req_err       = err_q;
    assign inval_entries = inval_q;
    assign inval_all     = inval_all_q;

endmodule

// File: rtl/mmu_sreg_ctrl_chk.sv
// Temporal checks on the register port, bound into every instance of
// mmu_sreg_ctrl. Assumes one-cycle requests with stable configuration.
module mmu_sreg_ctrl_chk #(
    parameter int N_ENTRIES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           cfg_mode,
    input logic [1:0]           cfg_access,
    input logic                 req_valid,
    input logic                 req_we,
    input logic [2:0]           req_reg,
    input logic                 req_err,
    input logic [N_ENTRIES-1:0] inval_entries,
    input logic                 inval_all,
    input logic [31:0]          index_q
);

    assert_global_refuse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && ((cfg_mode < 2'd2) || (cfg_access == 2'd0)) |=> req_err);

    assert_err_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> $past(req_valid));

    assert_err_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |-> (inval_entries == '0) && !inval_all);

    assert_search_index_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_we && (req_reg == 3'd5) && (cfg_mode >= 2'd2) && (cfg_access >= 2'd2)
        |=> (index_q[30:0] < 31'(N_ENTRIES)));

    assert_entry_pulse_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_entries != '0) |-> $past(req_valid && req_we && (req_reg == 3'd0)));

    assert_zone_pulse_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        inval_all |-> $past(req_valid && req_we && (req_reg == 3'd1)));

endmodule

bind mmu_sreg_ctrl mmu_sreg_ctrl_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_mode      (cfg_mode),
    .cfg_access    (cfg_access),
    .req_valid     (req_valid),
    .req_we        (req_we),
    .req_reg       (req_reg),
    .req_err       (req_err),
    .inval_entries (inval_entries),
    .inval_all     (inval_all),
    .index_q       (index_q)
);

// File: tb/tb_mmu_sreg_ctrl.sv
module tb_mmu_sreg_ctrl;

    localparam int NE = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic [1:0]    cfg_access = 2'd0;
    logic          req_valid = 1'b0;
    logic          req_we = 1'b0;
    logic [2:0]    req_reg = 3'd0;
    logic [31:0]   req_wdata = 32'd0;
    logic [31:0]   rd_data;
    logic          req_err;
    logic [NE-1:0] inval_entries;
    logic          inval_all;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  m_pid = 8'd0;
    logic [31:0] m_zone = 32'd0;
    logic [31:0] m_index = 32'd0;
    logic [31:0] m_rd = 32'd0;
    logic [31:0] m_tag [NE];
    logic [31:0] m_dat [NE];
    logic [7:0]  m_tid [NE];

    mmu_sreg_ctrl #(.N_ENTRIES(NE)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_mode      (cfg_mode),
        .cfg_access    (cfg_access),
        .req_valid     (req_valid),
        .req_we        (req_we),
        .req_reg       (req_reg),
        .req_wdata     (req_wdata),
        .rd_data       (rd_data),
        .req_err       (req_err),
        .inval_entries (inval_entries),
        .inval_all     (inval_all)
    );

    always #10 clk = ~clk;

    // Expected search result from R8/R9.
    function automatic logic [31:0] exp_search(input logic [31:0] v);
        logic [31:0] key = v & 32'hFFFF_FC00;
        for (int i = 0; i < NE; i++) begin
            logic [2:0]  sz = m_tag[i][9:7];
            logic [31:0] mask = ~((32'd1 << (10 + 2 * int'(sz))) - 32'd1);
            if (m_tag[i][6] && sz != 3'd0 && ((key & mask) == (m_tag[i] & mask))
                && (m_tid[i] == 8'd0 || m_tid[i] == m_pid))
                return 32'(i);
        end
        return 32'h8000_0000;
    endfunction

    // One request with model prediction and comparison of all outputs.
    task automatic access(input logic we, input int rg, input logic [31:0] wd, input string rq);
        logic       refused;
        logic [31:0] e_rd;
        logic [NE-1:0] e_inv;
        logic       e_all;
        int         ix;
        bit glob = (cfg_mode < 2) || (cfg_access == 0);
        bit need_lo = (rg == 0 || rg == 1 || rg == 3 || rg == 4);
        bit need_hi = (rg == 0 || rg == 1 || rg == 5);
        refused = glob || (!we && need_lo && !cfg_access[0]) || (we && need_hi && cfg_access < 2);
        ix = int'(m_index[2:0]);
        e_rd = m_rd; e_inv = '0; e_all = 1'b0;
        if (!we) begin
            if (refused) e_rd = 32'd0;
            else case (rg)
                0: e_rd = {24'd0, m_pid};
                1: e_rd = m_zone;
                2: e_rd = m_index;
                3: e_rd = m_dat[ix];
                4: begin e_rd = m_tag[ix]; m_pid = m_tid[ix]; end
                default: e_rd = 32'd0;
            endcase
        end else if (!refused) begin
            case (rg)
                0: begin
                    if (wd[7:0] != m_pid)
                        for (int i = 0; i < NE; i++) e_inv[i] = (m_tid[i] != 8'd0) && (m_tid[i] == m_pid);
                    m_pid = wd[7:0];
                end
                1: begin e_all = (wd != m_zone); m_zone = wd; end
                2: m_index = wd;
                3: m_dat[ix] = wd;
                4: begin m_tag[ix] = wd; m_tid[ix] = m_pid; end
                5: m_index = exp_search(wd);
                default: ;
            endcase
        end
        m_rd = e_rd;
        req_valid = 1'b1; req_we = we; req_reg = 3'(rg); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        checks++;
        if (req_err !== refused || rd_data !== e_rd || inval_entries !== e_inv || inval_all !== e_all) begin
            errors++;
            $display("FAIL %s we=%0d reg=%0d mode=%0d acc=%0d: err=%0b/%0b rd=%h/%h inv=%b/%b all=%0b/%0b (actual/expected)",
                     rq, we, rg, cfg_mode, cfg_access, req_err, refused, rd_data, e_rd,
                     inval_entries, e_inv, inval_all, e_all);
        end
    endtask

    // Idle cycle: every pulse must have dropped (R2, R10, R11).
    task automatic idle_check(input string rq);
        @(negedge clk);
        checks++;
        if (req_err !== 1'b0 || inval_entries !== '0 || inval_all !== 1'b0) begin
            errors++;
            $display("FAIL %s idle: err=%0b inv=%b all=%0b expected 0", rq, req_err, inval_entries, inval_all);
        end
    endtask

    function automatic logic [31:0] base_of(input int i);
        case (i)
            0: return 32'h0000_1000;
            1: return 32'h0001_0000;
            2: return 32'h0010_0000;
            3: return 32'h0100_0000;
            4: return 32'h0100_0000;
            5: return 32'h2000_0000;
            6: return 32'h3000_0400;
            default: return 32'h4000_0000;
        endcase
    endfunction

    function automatic int code_of(input int i);
        case (i)
            0: return 1; 1: return 2; 2: return 3; 3: return 5;
            4: return 4; 5: return 7; 6: return 0; default: return 1;
        endcase
    endfunction

    function automatic logic [7:0] owner_of(input int i);
        case (i)
            1, 5: return 8'd5;
            2:    return 8'd6;
            7:    return 8'd7;
            default: return 8'd0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) begin m_tag[i] = 0; m_dat[i] = 0; m_tid[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rd_data !== 32'd0 || req_err !== 1'b0 || inval_entries !== '0 || inval_all !== 1'b0) begin
            errors++;
            $display("FAIL R12 reset outputs rd=%h err=%0b inv=%b all=%0b expected 0",
                     rd_data, req_err, inval_entries, inval_all);
        end

        cfg_mode = 2'd3; cfg_access = 2'd3;
        // R12: every register and entry reads zero after reset.
        for (int r = 0; r < 8; r++) access(1'b0, r, 32'd0, "R12");
        for (int i = 0; i < NE; i++) begin
            access(1'b1, 2, 32'(i), "R12/R5");
            access(1'b0, 3, 32'd0, "R12");
            access(1'b0, 4, 32'd0, "R12");
        end

        // R6/R5: fill entries with their owner as translation ID.
        for (int i = 0; i < NE; i++) begin
            access(1'b1, 0, {24'd0, owner_of(i)}, "R10");
            access(1'b1, 2, 32'h0000_0F00 | 32'(i), "R5");
            access(1'b1, 4, base_of(i) | (32'(code_of(i)) << 7) | ((i == 7) ? 32'd0 : 32'h40) | 32'(i),
                   "R6");
            access(1'b1, 3, 32'hD000_0000 | (32'(i) * 32'h111), "R5");
        end
        idle_check("R10");

        // R7: read back; each tag read reloads the identifier.
        for (int i = NE - 1; i >= 0; i--) begin
            access(1'b1, 2, 32'(i), "R5");
            access(1'b0, 3, 32'd0, "R5");
            access(1'b0, 4, 32'd0, "R7");
            access(1'b0, 0, 32'd0, "R7");
        end

        // R8/R9: search grid over page edges and identifiers.
        for (int p = 0; p < 4; p++) begin
            logic [7:0] pv = (p == 0) ? 8'd0 : (p == 1) ? 8'd5 : (p == 2) ? 8'd6 : 8'd7;
            access(1'b1, 0, {24'd0, pv}, "R10");
            access(1'b1, 0, {24'd0, pv}, "R10");
            for (int i = 0; i < NE; i++) begin
                logic [31:0] span = 32'd1 << (10 + 2 * code_of(i));
                for (int k = 0; k < 3; k++) begin
                    logic [31:0] a = base_of(i) + ((k == 0) ? 32'd0 : (k == 1) ? span - 32'd4 : span);
                    access(1'b1, 5, a, "R8/R9");
                    access(1'b0, 2, 32'd0, "R8");
                end
            end
            access(1'b1, 5, 32'hF000_0000, "R8");
            access(1'b0, 2, 32'd0, "R8");
        end

        // R11: zone word changes and repeats.
        access(1'b1, 1, 32'h1234_5678, "R11");
        idle_check("R11");
        access(1'b1, 1, 32'h1234_5678, "R11");
        access(1'b1, 1, 32'h0, "R11");
        access(1'b0, 1, 32'd0, "R11");

        // R10: walk the identifier through owned values.
        for (int v = 0; v < 9; v++) begin
            access(1'b1, 0, 32'hAB00 | 32'(v), "R10");
            idle_check("R10");
        end

        // R1-R4 full sweep of mode, level, register and direction.
        for (int m = 0; m < 4; m++)
            for (int a = 0; a < 4; a++)
                for (int r = 0; r < 8; r++)
                    for (int w = 0; w < 2; w++) begin
                        cfg_mode = 2'(m); cfg_access = 2'(a);
                        access(w[0], r, 32'h5A00_0000 | 32'(m << 10) | 32'(a << 8) | 32'(r << 3) | 32'(w),
                               (m < 2 || a == 0) ? "R1/R2" : (w == 1) ? "R4" : "R3");
                    end

        // R2: final readback confirms the state the model expects.
        cfg_mode = 2'd2; cfg_access = 2'd3;
        for (int r = 0; r < 3; r++) access(1'b0, r, 32'd0, "R2");
        for (int i = 0; i < NE; i++) begin
            access(1'b1, 2, 32'(i), "R5");
            access(1'b0, 3, 32'd0, "R2");
            access(1'b0, 4, 32'd0, "R2");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule